// File: doc/BRIEF.md
# Full-Speed Host Frame Interval Timer

This block paces the frames of a full-speed host port. A 14-bit remaining-time counter steps down once per bit time, on a 12 MHz enable. When it has reached zero, the next bit-time enable reloads it from a frame-length register that software programs. Each reload also does the following:
- advances a 16-bit frame number, which wraps;
- produces a one-cycle start-of-frame strobe;
- sets a sticky start-of-frame flag.

Software changes the frame length by writing a new value together with a toggle bit. The counter copies that toggle when it reloads, so software can tell which frame first ran with the new length. A comparator reports whether enough time remains in the current frame for a low-speed transaction to begin. It compares the remaining count against a programmed threshold.

The timer runs only while the controller is in its operational state, given by the `run` input. Outside that state the remaining count is held at zero. As a result, the first bit-time enable after `run` rises starts a frame at once. The remaining count, its toggle and the frame number can be read at any time with no effect on counting.

Top module: `usb_frame_timer`

## Requirements
- R1: After a synchronous reset, the registers take these values:

  | Register | Reset value |
  |---|---|
  | Frame length | 11999 |
  | Length toggle | 0 |
  | Low-speed threshold | 1576 |
  | Remaining count | 0 |
  | Remaining toggle | 0 |
  | Frame number | 0 |
  | Start-of-frame strobe | 0 |
  | Start-of-frame flag | 0 |
- R2: While `run` is low, the remaining count is 0 from the next cycle on. The frame number and the remaining toggle hold, and no start-of-frame strobe occurs.
- R3: While `run` is high, each cycle with `bit_tick` high and a non-zero remaining count lowers the count by exactly 1. A cycle with `bit_tick` low changes neither the remaining count nor the frame number.
- R4: A cycle with `run` and `bit_tick` high and a remaining count of 0 loads the count from the frame-length register. A frame therefore lasts frame length + 1 bit times. `sof_pulse` is high for exactly the one cycle in which the reloaded value is first visible.
- R5: The frame number increases by 1 on every reload and wraps from 16'hFFFF to 0.
- R6: `rem_toggle` takes the value of the length toggle only on a reload. At any other time it holds.
- R7: `ls_ok` is high exactly when `run` is high and the remaining count is greater than or equal to the threshold, compared as unsigned numbers.
- R8: `sof_status` is set by every reload and stays set until a cycle with `sof_ack` high. A reload in the same cycle as `sof_ack` leaves it set.
- R9: A write of the frame length or the threshold is visible in the cycle after its strobe. A frame-length write in the middle of a frame does not change the countdown in progress, and the new length applies from the next reload onward.
- R10: The first `bit_tick` after `run` rises starts a new frame. It reloads the count, advances the frame number and strobes `sof_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | Full-speed bit-time enable (12 MHz) |
| run | input | 1 | Controller is in the operational state |
| ivl_we | input | 1 | Write strobe for frame length and length toggle |
| ivl_data | input | 14 | New frame length, in bit times minus one |
| ivl_tgl | input | 1 | New length toggle value |
| ls_we | input | 1 | Write strobe for the low-speed threshold |
| ls_data | input | 14 | New low-speed threshold |
| sof_ack | input | 1 | Clears the start-of-frame flag |
| ivl_rd | output | 14 | Current frame length |
| ivl_tgl_rd | output | 1 | Current length toggle |
| ls_rd | output | 14 | Current low-speed threshold |
| rem_count | output | 14 | Bit times left in the current frame |
| rem_toggle | output | 1 | Length toggle copied at the last reload |
| frame_num | output | 16 | Frame number |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| sof_status | output | 1 | Sticky start-of-frame flag |
| ls_ok | output | 1 | A low-speed transaction may start now |

## Verification
Every registered result is due one clock after the edge that samples its cause:
- the remaining count, its toggle, the frame number, `sof_pulse` and `sof_status` follow a `bit_tick` or `sof_ack` after one clock;
- the configuration readbacks follow their write strobe after one clock.

`ls_ok` is combinational from registered state, so it is due in the same cycle as the remaining count it depends on. The bench drives every input a quarter period after a rising edge and checks the outputs a quarter period after the following edge. Each expected value is therefore read exactly one register stage after its stimulus. For each sweep, the expected count and frame number come from the tick index, the programmed length and the gap between ticks.

// File: rtl/ft_pkg.sv
// Package: shared constants and types of the frame interval timer.
// Assumes: a full-speed bit clock enable of 12 MHz, so 12000 ticks per 1 ms frame.
package ft_pkg;

    // Default widths and reset values of the timer
    localparam int FT_CNT_W     = 14;
    localparam int FT_FN_W      = 16;
    localparam int FT_IVL_RESET = 11999;
    localparam int FT_LS_RESET  = 1576;

    // Action taken by the remaining-time counter in a cycle
    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_CLEAR  = 2'd1,
        CNT_DEC    = 2'd2,
        CNT_RELOAD = 2'd3
    } ft_cnt_op_e;

endpackage

// File: rtl/ft_cfg_regs.sv
// Module: ft_cfg_regs
// Holds the frame length, its handover toggle and the low-speed threshold.
// Assumes: single-cycle write strobes; a written value is visible the next cycle.
module ft_cfg_regs #(
    parameter int CNT_W     = ft_pkg::FT_CNT_W,
    parameter int IVL_RESET = ft_pkg::FT_IVL_RESET,
    parameter int LS_RESET  = ft_pkg::FT_LS_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_we,
    input  logic [CNT_W-1:0] ivl_data,
    input  logic             ivl_tgl,
    input  logic             ls_we,
    input  logic [CNT_W-1:0] ls_data,
    output logic [CNT_W-1:0] ivl_q,
    output logic             ivl_tgl_q,
    output logic [CNT_W-1:0] ls_q
);

    localparam logic [CNT_W-1:0] IVL_INIT = CNT_W'(IVL_RESET);
    localparam logic [CNT_W-1:0] LS_INIT  = CNT_W'(LS_RESET);

    // Frame length and its toggle, written together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q     <= IVL_INIT;
            ivl_tgl_q <= 1'b0;
        end else if (ivl_we) begin
            ivl_q     <= ivl_data;
            ivl_tgl_q <= ivl_tgl;
        end
    end

    // Low-speed threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q <= LS_INIT;
        end else if (ls_we) begin
            ls_q <= ls_data;
        end
    end

endmodule

// File: rtl/ft_remaining.sv
// Module: ft_remaining
// Remaining-time down counter. It steps on bit ticks, reloads after reaching
// zero and copies the length toggle on reload.
// Assumes: the frame length is already registered; run low parks the count at zero.
module ft_remaining #(
    parameter int CNT_W = ft_pkg::FT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] ivl_q,
    input  logic             ivl_tgl_q,
    output logic [CNT_W-1:0] rem_q,
    output logic             rem_tgl_q,
    output logic             reload_o
);
    import ft_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ft_cnt_op_e op;

    // Pick this cycle's counter action
    always_comb begin
        if (!run)                 op = CNT_CLEAR;
        else if (!bit_tick)       op = CNT_HOLD;
        else if (rem_q == CNT_ZERO) op = CNT_RELOAD;
        else                      op = CNT_DEC;
    end

    assign reload_o = (op == CNT_RELOAD);

    // Counter register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= CNT_ZERO;
        end else begin
            unique case (op)
                CNT_CLEAR:  rem_q <= CNT_ZERO;
                CNT_DEC:    rem_q <= rem_q - CNT_ONE;
                CNT_RELOAD: rem_q <= ivl_q;
                default:    rem_q <= rem_q;
            endcase
        end
    end

    // Toggle handover, taken only at a reload
    always_ff @(posedge clk) begin
        if (!rst_n)        rem_tgl_q <= 1'b0;
        else if (reload_o) rem_tgl_q <= ivl_tgl_q;
    end

endmodule

// File: rtl/ft_frame_seq.sv
// Module: ft_frame_seq
// Frame number, start-of-frame strobe and sticky start-of-frame flag.
// Assumes: reload_i is a single-cycle request from the counter; a set wins over an acknowledge.
module ft_frame_seq #(
    parameter int FN_W = ft_pkg::FT_FN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload_i,
    input  logic            sof_ack,
    output logic [FN_W-1:0] frame_q,
    output logic            sof_pulse_q,
    output logic            sof_status_q
);

    localparam logic [FN_W-1:0] FN_ONE = FN_W'(1);

    // Frame number advances with natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_q <= '0;
        else if (reload_i) frame_q <= frame_q + FN_ONE;
    end

    // Registered strobe, aligned with the reloaded count
    always_ff @(posedge clk) begin
        if (!rst_n) sof_pulse_q <= 1'b0;
        else        sof_pulse_q <= reload_i;
    end

    // Sticky flag: set has priority over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        sof_status_q <= 1'b0;
        else if (reload_i) sof_status_q <= 1'b1;
        else if (sof_ack)  sof_status_q <= 1'b0;
    end

endmodule

// File: rtl/ft_ls_gate.sv
// Module: ft_ls_gate
// Low-speed start permission: enough time is left in the frame.
// Assumes: both operands are registered, so the result is stable within a cycle.
module ft_ls_gate #(
    parameter int CNT_W = ft_pkg::FT_CNT_W
) (
    input  logic             run,
    input  logic [CNT_W-1:0] rem_q,
    input  logic [CNT_W-1:0] ls_q,
    output logic             ls_ok
);

    // Unsigned compare, gated by the operational state
    always_comb begin
        ls_ok = run && (rem_q >= ls_q);
    end

endmodule

// File: rtl/usb_frame_timer.sv
// Module: usb_frame_timer
// Top level of the full-speed host frame interval timer.
// Assumes: bit_tick is a one-cycle enable at the bit rate; every readback has no side effect.
module usb_frame_timer #(
    parameter int CNT_W     = ft_pkg::FT_CNT_W,
    parameter int FN_W      = ft_pkg::FT_FN_W,
    parameter int IVL_RESET = ft_pkg::FT_IVL_RESET,
    parameter int LS_RESET  = ft_pkg::FT_LS_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             run,
    input  logic             ivl_we,
    input  logic [CNT_W-1:0] ivl_data,
    input  logic             ivl_tgl,
    input  logic             ls_we,
    input  logic [CNT_W-1:0] ls_data,
    input  logic             sof_ack,
    output logic [CNT_W-1:0] ivl_rd,
    output logic             ivl_tgl_rd,
    output logic [CNT_W-1:0] ls_rd,
    output logic [CNT_W-1:0] rem_count,
    output logic             rem_toggle,
    output logic [FN_W-1:0]  frame_num,
    output logic             sof_pulse,
    output logic             sof_status,
    output logic             ls_ok
);

    logic reload;

    ft_cfg_regs #(
        .CNT_W(CNT_W), .IVL_RESET(IVL_RESET), .LS_RESET(LS_RESET)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .ivl_we(ivl_we), .ivl_data(ivl_data), .ivl_tgl(ivl_tgl),
        .ls_we(ls_we), .ls_data(ls_data),
        .ivl_q(ivl_rd), .ivl_tgl_q(ivl_tgl_rd), .ls_q(ls_rd)
    );

    ft_remaining #(.CNT_W(CNT_W)) rem_i (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
        .ivl_q(ivl_rd), .ivl_tgl_q(ivl_tgl_rd),
        .rem_q(rem_count), .rem_tgl_q(rem_toggle), .reload_o(reload)
    );

    ft_frame_seq #(.FN_W(FN_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .reload_i(reload), .sof_ack(sof_ack),
        .frame_q(frame_num), .sof_pulse_q(sof_pulse), .sof_status_q(sof_status)
    );

    ft_ls_gate #(.CNT_W(CNT_W)) gate_i (
        .run(run), .rem_q(rem_count), .ls_q(ls_rd), .ls_ok(ls_ok)
    );

endmodule

// File: rtl/ft_checker.sv
// Module: ft_checker
// Temporal checks on the frame interval timer, bound to usb_frame_timer.
// Assumes: synchronous active-low reset; all checks are disabled while it is low.
module ft_checker #(
    parameter int CNT_W = ft_pkg::FT_CNT_W,
    parameter int FN_W  = ft_pkg::FT_FN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             bit_tick,
    input logic             sof_ack,
    input logic [CNT_W-1:0] ivl_rd,
    input logic             ivl_tgl_rd,
    input logic [CNT_W-1:0] rem_count,
    input logic             rem_toggle,
    input logic [FN_W-1:0]  frame_num,
    input logic             sof_pulse,
    input logic             sof_status,
    input logic             ls_ok
);

    localparam logic [CNT_W-1:0] C_ZERO = '0;
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [FN_W-1:0]  F_ONE  = FN_W'(1);

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (rem_count == C_ZERO) && !sof_pulse && $stable(frame_num)); // R2

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && bit_tick && (rem_count != C_ZERO) |=> rem_count == $past(rem_count) - C_ONE); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        run && !bit_tick |=> $stable(rem_count) && $stable(frame_num) && !sof_pulse); // R3

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        run && bit_tick && (rem_count == C_ZERO) |=> (rem_count == $past(ivl_rd)) && sof_pulse); // R4

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && bit_tick && (rem_count == C_ZERO) |=> frame_num == $past(frame_num) + F_ONE); // R5

    AST_TOGGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        run && bit_tick && (rem_count == C_ZERO) |=> rem_toggle == $past(ivl_tgl_rd)); // R6

    AST_LS_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ls_ok); // R7

    AST_SOF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> sof_status); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sof_status && !sof_ack |=> sof_status); // R8

endmodule

bind usb_frame_timer ft_checker #(.CNT_W(CNT_W), .FN_W(FN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick), .sof_ack(sof_ack),
    .ivl_rd(ivl_rd), .ivl_tgl_rd(ivl_tgl_rd), .rem_count(rem_count),
    .rem_toggle(rem_toggle), .frame_num(frame_num), .sof_pulse(sof_pulse),
    .sof_status(sof_status), .ls_ok(ls_ok)
);

// File: tb/usb_frame_timer_tb_top.sv
// Bench: sweeps frame lengths, tick spacings and thresholds, then targets
// toggle handover, mid-frame writes, flag priority and frame-number wrap.
module usb_frame_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 14;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          run = 1'b0;
    logic          ivl_we = 1'b0;
    logic [CW-1:0] ivl_data = '0;
    logic          ivl_tgl = 1'b0;
    logic          ls_we = 1'b0;
    logic [CW-1:0] ls_data = '0;
    logic          sof_ack = 1'b0;
    logic [CW-1:0] ivl_rd;
    logic          ivl_tgl_rd;
    logic [CW-1:0] ls_rd;
    logic [CW-1:0] rem_count;
    logic          rem_toggle;
    logic [FW-1:0] frame_num;
    logic          sof_pulse;
    logic          sof_status;
    logic          ls_ok;

    int n_vec = 0;
    int n_bad = 0;
    int exp_fn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_frame_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
        .ivl_we(ivl_we), .ivl_data(ivl_data), .ivl_tgl(ivl_tgl),
        .ls_we(ls_we), .ls_data(ls_data), .sof_ack(sof_ack),
        .ivl_rd(ivl_rd), .ivl_tgl_rd(ivl_tgl_rd), .ls_rd(ls_rd),
        .rem_count(rem_count), .rem_toggle(rem_toggle), .frame_num(frame_num),
        .sof_pulse(sof_pulse), .sof_status(sof_status), .ls_ok(ls_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock; return a quarter period after the edge
    task automatic cyc();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
    endtask

    // One configuration: length ivl, ticks every gap cycles, threshold thr
    task automatic sweep(input int ivl, input int gap, input int thr);
        int prev_rem;
        int exp_rem;
        int p;
        run = 1'b0;
        cyc();
        chk("R2 count parked", int'(rem_count), 0);
        chk("R2 frame held", int'(frame_num), exp_fn);
        ivl_we = 1'b1; ivl_data = CW'(ivl); ivl_tgl = 1'b0;
        ls_we = 1'b1;  ls_data = CW'(thr);
        cyc();
        ivl_we = 1'b0; ls_we = 1'b0;
        chk("R9 length readback", int'(ivl_rd), ivl);
        chk("R9 threshold readback", int'(ls_rd), thr);
        chk("R7 gate off when stopped", int'(ls_ok), 0);
        run = 1'b1;
        prev_rem = 0;
        for (int t = 1; t <= 3 * (ivl + 1) + 1; t++) begin
            for (int g = 1; g < gap; g++) begin
                cyc();
                chk("R3 idle count", int'(rem_count), prev_rem);
                chk("R3 idle no strobe", int'(sof_pulse), 0);
                chk("R7 gate idle", int'(ls_ok), int'(prev_rem >= thr));
            end
            tick();
            p = (t - 1) % (ivl + 1);
            exp_rem = ivl - p;
            if (p == 0) exp_fn = (exp_fn + 1) % 65536;
            chk(t == 1 ? "R10 first tick reloads" : "R3 R4 count", int'(rem_count), exp_rem);
            chk("R5 frame number", int'(frame_num), exp_fn);
            chk("R4 strobe", int'(sof_pulse), int'(p == 0));
            chk("R7 gate", int'(ls_ok), int'(exp_rem >= thr));
            prev_rem = exp_rem;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 length", int'(ivl_rd), 11999);
        chk("R1 length toggle", int'(ivl_tgl_rd), 0);
        chk("R1 threshold", int'(ls_rd), 1576);
        chk("R1 count", int'(rem_count), 0);
        chk("R1 count toggle", int'(rem_toggle), 0);
        chk("R1 frame", int'(frame_num), 0);
        chk("R1 strobe", int'(sof_pulse), 0);
        chk("R1 flag", int'(sof_status), 0);

        // R2: ticks while stopped do nothing
        tick(); tick();
        chk("R2 no count while stopped", int'(rem_count), 0);
        chk("R2 no frame while stopped", int'(frame_num), 0);
        chk("R2 no strobe while stopped", int'(sof_pulse), 0);

        // Near-exhaustive sweep over small lengths, spacings and thresholds
        for (int ivl = 0; ivl <= 6; ivl++)
            for (int gap = 1; gap <= 2; gap++) begin
                sweep(ivl, gap, 0);
                sweep(ivl, gap, ivl / 2);
                sweep(ivl, gap, ivl + 1);
            end

        // R6 and R9: toggle handover and a mid-frame length write
        run = 1'b0; cyc();
        chk("R2 toggle held when stopped", int'(rem_toggle), 0);
        ivl_we = 1'b1; ivl_data = CW'(3); ivl_tgl = 1'b1;
        ls_we = 1'b1; ls_data = '0;
        cyc();
        ivl_we = 1'b0; ls_we = 1'b0;
        run = 1'b1;
        cyc();
        chk("R6 toggle waits for reload", int'(rem_toggle), 0);
        tick(); exp_fn = (exp_fn + 1) % 65536;
        chk("R6 toggle copied", int'(rem_toggle), 1);
        chk("R4 reload 3", int'(rem_count), 3);
        tick();
        ivl_we = 1'b1; ivl_data = CW'(5); ivl_tgl = 1'b0;
        cyc();
        ivl_we = 1'b0;
        chk("R9 countdown kept", int'(rem_count), 2);
        chk("R9 new length visible", int'(ivl_rd), 5);
        chk("R6 toggle held mid-frame", int'(rem_toggle), 1);
        tick(); tick();
        chk("R3 reached zero", int'(rem_count), 0);
        chk("R6 toggle still held", int'(rem_toggle), 1);
        tick(); exp_fn = (exp_fn + 1) % 65536;
        chk("R9 new length on reload", int'(rem_count), 5);
        chk("R6 toggle handed over", int'(rem_toggle), 0);
        chk("R5 frame after handover", int'(frame_num), exp_fn);

        // R7 and R9: threshold edges against a held count of 5
        ls_we = 1'b1; ls_data = CW'(6); cyc(); ls_we = 1'b0;
        chk("R7 count below threshold", int'(ls_ok), 0);
        ls_we = 1'b1; ls_data = CW'(5); cyc(); ls_we = 1'b0;
        chk("R7 count equal threshold", int'(ls_ok), 1);

        // R8: acknowledge, then set winning over acknowledge
        chk("R8 flag set", int'(sof_status), 1);
        sof_ack = 1'b1; cyc(); sof_ack = 1'b0;
        chk("R8 acknowledge clears", int'(sof_status), 0);
        repeat (5) tick();
        chk("R3 count back to zero", int'(rem_count), 0);
        sof_ack = 1'b1; bit_tick = 1'b1; cyc(); sof_ack = 1'b0; bit_tick = 1'b0;
        exp_fn = (exp_fn + 1) % 65536;
        chk("R8 set beats acknowledge", int'(sof_status), 1);
        chk("R4 strobe with acknowledge", int'(sof_pulse), 1);
        cyc();
        chk("R8 flag stays", int'(sof_status), 1);
        chk("R4 strobe one cycle", int'(sof_pulse), 0);
        sof_ack = 1'b1; cyc(); sof_ack = 1'b0;
        chk("R8 cleared again", int'(sof_status), 0);

        // R5: frame number wrap with one-tick frames
        run = 1'b0;
        ivl_we = 1'b1; ivl_data = '0; ivl_tgl = 1'b0;
        cyc();
        ivl_we = 1'b0;
        run = 1'b1;
        bit_tick = 1'b1;
        for (int k = 0; k < 65535 - exp_fn; k++) cyc();
        chk("R5 frame at top", int'(frame_num), 65535);
        cyc();
        bit_tick = 1'b0;
        chk("R5 frame wraps to zero", int'(frame_num), 0);
        chk("R4 strobe on wrap", int'(sof_pulse), 1);
        chk("R4 zero-length frame", int'(rem_count), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule